// File: doc/BRIEF.md
# Iterative Shift-Add Sine/Cosine Unit

This block returns the cosine and the sine of an angle given as an unsigned binary fraction of a full turn. The whole circle spans 2^ANG_W codes. With the default 32-bit width, 0x40000000 is a quarter turn, 0x15555555 is 30 degrees, and one degree is roughly 0x00B60B60. The unit runs in rotation mode and works one micro-rotation per clock. A single datapath does all the work: a variable arithmetic right shift on each of x and y, three adder/subtractors, and a small constant table of arctangents held in the same turn-fraction encoding. No multiplier is used.

The top two angle bits select a quadrant, and the unit folds the angle into the half-plane between -90 and +90 degrees before any iteration. For the second and third quadrants, the starting vector is swapped and negated so that the result covers the full circle. The starting x is the inverse of the accumulated rotation gain, so both results come out at unit amplitude in signed Q1.30 format.

A one-cycle `start` pulse captures `angle`, and the unit then runs `ITERS` micro-rotations. After that, `done` pulses for one cycle and the results stay on the outputs until the next accepted start.

Top module: `sincos_cordic`

## Requirements
- R1: During and after a synchronous reset, `busy` and `done` are low and `cos_out` and `sin_out` are zero.
- R2: A `start` high while `busy` is low is accepted at that clock edge, and `busy` is high in the following cycle.
- R3: After an accepted start, `busy` stays high for exactly `ITERS` cycles (30 by default). `done` is then high for exactly one cycle, which is the first cycle with `busy` low.
- R4: A `start` seen while `busy` is high is ignored. The run in progress keeps its timing and its result.
- R5: With `done` high, `cos_out` and `sin_out` are signed Q1.30 values (2^30 represents 1.0). They are within 256 LSB of the cosine and sine of angle·2π/2^32 for any angle on the circle.
- R6: Angles 0x00000000, 0x40000000, 0x80000000 and 0xC0000000 produce (1,0), (0,1), (-1,0) and (0,-1), each within 256 LSB.
- R7: After `done`, `cos_out` and `sin_out` hold their values until the next accepted start, whatever `angle` does.
- R8: `angle` is sampled only at an accepted start. Changing it while `busy` is high does not alter the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request pulse, honoured only while idle |
| angle | input | ANG_W (32) | Unsigned fraction of a full turn |
| busy | output | 1 | Micro-rotations in progress |
| done | output | 1 | One-cycle pulse when results are ready |
| cos_out | output | DATA_W (32) | Cosine, signed Q1.30 |
| sin_out | output | DATA_W (32) | Sine, signed Q1.30 |

## Verification
The properties take it for granted that reset is held for at least one clock edge before the first `start`. They also rely on `start` being the only input that changes the unit's state. The amplitude bound assumes no more than 31 iterations, so the arctangent table is never read past its end.

The stimulus changes `start` and `angle` only on falling clock edges. Apart from the deliberate ignored-request and changing-angle runs, it issues a new request only after `done` has been seen. It sweeps 512 angles spread over all four quadrants, and the expected values come from real-valued trigonometry computed in the bench.

// File: rtl/sincos_pkg.sv
package sincos_pkg;

    localparam int TABLE_W   = 32;
    localparam int TABLE_LEN = 31;

    // arctangent of 2^-idx as a fraction of a full turn (2^32 = 360 degrees)
    function automatic logic [TABLE_W-1:0] atan_turn(input int unsigned idx);
        logic [TABLE_W-1:0] v;
        case (idx)
            0:  v = 32'h20000000;
            1:  v = 32'h12E4051E;
            2:  v = 32'h09FB385B;
            3:  v = 32'h051111D4;
            4:  v = 32'h028B0D43;
            5:  v = 32'h0145D7E1;
            6:  v = 32'h00A2F61E;
            7:  v = 32'h00517C55;
            8:  v = 32'h0028BE53;
            9:  v = 32'h00145F2F;
            10: v = 32'h000A2F98;
            11: v = 32'h000517CC;
            12: v = 32'h00028BE6;
            13: v = 32'h000145F3;
            14: v = 32'h0000A2FA;
            15: v = 32'h0000517D;
            16: v = 32'h000028BE;
            17: v = 32'h0000145F;
            18: v = 32'h00000A30;
            19: v = 32'h00000518;
            20: v = 32'h0000028C;
            21: v = 32'h00000146;
            22: v = 32'h000000A3;
            23: v = 32'h00000051;
            24: v = 32'h00000029;
            25: v = 32'h00000014;
            26: v = 32'h0000000A;
            27: v = 32'h00000005;
            28: v = 32'h00000003;
            29: v = 32'h00000001;
            30: v = 32'h00000001;
            default: v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/sincos_fold.sv
module sincos_fold #(
    parameter int ANG_W  = 32,
    parameter int DATA_W = 32,
    parameter logic signed [DATA_W-1:0] GAIN_INIT = 32'sh26DD3B6A
) (
    input  logic [ANG_W-1:0]         angle,
    output logic signed [DATA_W-1:0] x_init,
    output logic signed [DATA_W-1:0] y_init,
    output logic signed [ANG_W-1:0]  z_init
);
    localparam logic [ANG_W-1:0] QUARTER = ANG_W'(1) << (ANG_W - 2);

    always_comb begin
        unique case (angle[ANG_W-1 -: 2])
            2'b01: begin           // second quadrant: start at +90 degrees
                x_init = '0;
                y_init = GAIN_INIT;
                z_init = $signed(angle - QUARTER);
            end
            2'b10: begin           // third quadrant: start at -90 degrees
                x_init = '0;
                y_init = -GAIN_INIT;
                z_init = $signed(angle + QUARTER);
            end
            default: begin         // first and fourth quadrants need no fold
                x_init = GAIN_INIT;
                y_init = '0;
                z_init = $signed(angle);
            end
        endcase
    end
endmodule

// File: rtl/sincos_micro.sv
module sincos_micro #(
    parameter int ANG_W  = 32,
    parameter int DATA_W = 32,
    parameter int SH_W   = 5
) (
    input  logic signed [DATA_W-1:0] x_in,
    input  logic signed [DATA_W-1:0] y_in,
    input  logic signed [ANG_W-1:0]  z_in,
    input  logic [SH_W-1:0]          shift,
    input  logic [ANG_W-1:0]         step_angle,
    output logic signed [DATA_W-1:0] x_out,
    output logic signed [DATA_W-1:0] y_out,
    output logic signed [ANG_W-1:0]  z_out
);
    logic signed [DATA_W-1:0] x_sh;
    logic signed [DATA_W-1:0] y_sh;

    always_comb begin
        x_sh = x_in >>> shift;
        y_sh = y_in >>> shift;
        if (z_in[ANG_W-1]) begin   // residual negative: rotate clockwise
            x_out = x_in + y_sh;
            y_out = y_in - x_sh;
            z_out = z_in + $signed(step_angle);
        end else begin
            x_out = x_in - y_sh;
            y_out = y_in + x_sh;
            z_out = z_in - $signed(step_angle);
        end
    end
endmodule

// File: rtl/sincos_cordic.sv
module sincos_cordic #(
    parameter int ANG_W  = 32,
    parameter int DATA_W = 32,
    parameter int ITERS  = 30,
    parameter logic signed [DATA_W-1:0] GAIN_INIT = 32'sh26DD3B6A
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic [ANG_W-1:0]         angle,
    output logic                     busy,
    output logic                     done,
    output logic signed [DATA_W-1:0] cos_out,
    output logic signed [DATA_W-1:0] sin_out
);
    import sincos_pkg::*;

    localparam int CNT_W = $clog2(ITERS + 1);

    typedef struct packed {
        logic                     busy;
        logic                     done;
        logic [CNT_W-1:0]         cnt;
        logic signed [DATA_W-1:0] x;
        logic signed [DATA_W-1:0] y;
        logic signed [ANG_W-1:0]  z;
    } state_t;

    state_t st_d, st_q;

    logic signed [DATA_W-1:0] x0_w, y0_w, x1_w, y1_w;
    logic signed [ANG_W-1:0]  z0_w, z1_w;
    logic [ANG_W-1:0]         step_w;
    logic [TABLE_W-1:0]       table_w;

    sincos_fold #(.ANG_W(ANG_W), .DATA_W(DATA_W), .GAIN_INIT(GAIN_INIT)) u_fold (
        .angle (angle),
        .x_init(x0_w),
        .y_init(y0_w),
        .z_init(z0_w)
    );

    assign table_w = atan_turn(32'(st_q.cnt));
    assign step_w  = ANG_W'(table_w >> (TABLE_W - ANG_W));

    sincos_micro #(.ANG_W(ANG_W), .DATA_W(DATA_W), .SH_W(CNT_W)) u_micro (
        .x_in      (st_q.x),
        .y_in      (st_q.y),
        .z_in      (st_q.z),
        .shift     (st_q.cnt),
        .step_angle(step_w),
        .x_out     (x1_w),
        .y_out     (y1_w),
        .z_out     (z1_w)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.busy) begin
            st_d.x   = x1_w;
            st_d.y   = y1_w;
            st_d.z   = z1_w;
            st_d.cnt = st_q.cnt + CNT_W'(1);
            if (st_q.cnt == CNT_W'(ITERS - 1)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end else if (start) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
            st_d.x    = x0_w;
            st_d.y    = y0_w;
            st_d.z    = z0_w;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy    = st_q.busy;
    assign done    = st_q.done;
    assign cos_out = st_q.x;
    assign sin_out = st_q.y;
endmodule

// File: rtl/sincos_checks.sv
module sincos_checks #(
    parameter int DATA_W = 32,
    parameter int ITERS  = 30
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     start,
    input logic                     busy,
    input logic                     done,
    input logic signed [DATA_W-1:0] cos_out,
    input logic signed [DATA_W-1:0] sin_out
);
    localparam int RUN_W = $clog2(ITERS + 2);
    localparam logic signed [DATA_W-1:0] AMP_MAX = DATA_W'(1) <<< (DATA_W - 2);
    localparam logic signed [DATA_W-1:0] AMP_TOL = 1024;

    logic [RUN_W-1:0] run_len;

    always_ff @(posedge clk) begin
        if (rst || !busy) run_len <= '0;
        else              run_len <= run_len + RUN_W'(1);
    end

    // R1: reset clears the flags
    p_reset_idle_r1: assert property (@(posedge clk) rst |=> !busy && !done);

    // R2: idle start begins a run
    p_start_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R3: run keeps going until its last iteration
    p_run_continues_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && run_len < RUN_W'(ITERS - 1)) |=> busy && !done);

    // R3: last iteration ends the run with a done pulse
    p_run_ends_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && run_len == RUN_W'(ITERS - 1)) |=> !busy && done);

    // R3: done lasts one cycle
    p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R4: a request while busy does not restart the count
    p_ignore_busy_start_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && start && run_len < RUN_W'(ITERS - 1)) |=> run_len == $past(run_len) + RUN_W'(1));

    // R5: result amplitude stays within unit range
    p_amplitude_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> (cos_out <= AMP_MAX + AMP_TOL) && (cos_out >= -AMP_MAX - AMP_TOL)
              && (sin_out <= AMP_MAX + AMP_TOL) && (sin_out >= -AMP_MAX - AMP_TOL));

    // R7: idle without request holds results
    p_hold_results_r7: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(cos_out) && $stable(sin_out));
endmodule

bind sincos_cordic sincos_checks #(.DATA_W(DATA_W), .ITERS(ITERS)) u_checks (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .cos_out(cos_out),
    .sin_out(sin_out)
);

// File: tb/sincos_cordic_tb.sv
module sincos_cordic_tb;
    localparam int ITERS = 30;
    localparam int TOL   = 256;
    localparam real TWO_PI = 6.283185307179586;
    localparam real SCALE  = 1073741824.0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] angle = '0;
    logic        busy, done;
    logic signed [31:0] cos_out, sin_out;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    sincos_cordic u_dut (
        .clk(clk), .rst(rst), .start(start), .angle(angle),
        .busy(busy), .done(done), .cos_out(cos_out), .sin_out(sin_out)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint exp_val(input logic [31:0] a, input bit want_sin);
        real ph;
        ph = real'(a) * TWO_PI / 4294967296.0;
        return longint'($rtoi((want_sin ? $sin(ph) : $cos(ph)) * SCALE + (want_sin ? ($sin(ph) >= 0 ? 0.5 : -0.5) : ($cos(ph) >= 0 ? 0.5 : -0.5))));
    endfunction

    task automatic check_result(input logic [31:0] a, input string req);
        longint ec, es, dc, ds;
        ec = exp_val(a, 1'b0);
        es = exp_val(a, 1'b1);
        dc = longint'(cos_out) - ec;
        ds = longint'(sin_out) - es;
        check((dc <= TOL) && (dc >= -TOL), req, "cosine", longint'(cos_out), ec);
        check((ds <= TOL) && (ds >= -TOL), req, "sine", longint'(sin_out), es);
    endtask

    // drives one request; optionally disturbs start/angle in the middle
    task automatic run_one(input logic [31:0] a, input bit disturb);
        int cyc;
        @(negedge clk);
        angle = a;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2", "busy after start", longint'(busy), 1);
        cyc = 0;
        while (!done && cyc < 100) begin
            @(negedge clk);
            cyc++;
            if (disturb && cyc == 5) begin
                start = 1'b1;
                angle = a ^ 32'h6A5C_3F01;
            end else if (disturb && cyc == 6) begin
                start = 1'b0;
            end
        end
        check(cyc == ITERS, disturb ? "R4" : "R3", "run length", cyc, ITERS);
        check(busy == 1'b0, "R3", "busy at done", longint'(busy), 0);
        check_result(a, disturb ? "R8" : "R5");
        angle = ~a;
        @(negedge clk);
        check(done == 1'b0, "R3", "done width", longint'(done), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R1", "flags in reset", longint'({busy, done}), 0);
        check(cos_out == 0 && sin_out == 0, "R1", "outputs in reset", longint'(cos_out), 0);
        rst = 1'b0;

        // R6: quadrant boundaries
        for (int q = 0; q < 4; q++) begin
            run_one(32'(q) << 30, 1'b0);
            check_result(32'(q) << 30, "R6");
        end

        // R5: 30 degrees and sweep over the full circle
        run_one(32'h15555555, 1'b0);
        for (int k = 0; k < 512; k++) begin
            run_one((32'(k) << 23) | ((32'(k) * 32'd2654435) & 32'h007FFFFF), 1'b0);
        end

        // R4, R8: request and angle changes during a run are ignored
        run_one(32'h2AAAAAAB, 1'b1);
        run_one(32'hD0000123, 1'b1);

        // R7: results hold while idle with a changing angle
        begin
            logic signed [31:0] c0, s0;
            c0 = cos_out;
            s0 = sin_out;
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                angle = 32'(i) * 32'h1357_9BDF;
            end
            check(cos_out == c0, "R7", "cosine hold", longint'(cos_out), longint'(c0));
            check(sin_out == s0, "R7", "sine hold", longint'(sin_out), longint'(s0));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1600000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule